// File: doc/BRIEF.md
# Memory Test Control and Status Register Bank

This block is the software-facing register bank of a memory test engine. A 32-bit memory-mapped bus writes configuration and issues commands, and the block turns those writes into the signals that drive the test sequencer and the memory controller. The same bus reads back the test outcome, the controller's calibration and ready state, the error count and the configuration values.

The control word mixes two kinds of bits. The three command bits (tester reset, controller reset, run) act only when they change from 0 to 1, so software writes 1 and then 0 to issue a command. The tester reset and run commands each become a one-cycle pulse. The controller reset request is held high for a parameterised minimum number of cycles. The remaining control bits are levels that select the manual access path and the test modes.

The status word shows the sequencer and controller flags as they are now. The exception is the ECC flag, which latches the controller's error interrupt and holds it until the next tester reset command. Reads complete with a one-cycle data-ready pulse. The address-ready output is always high.

Top module: `memtest_csr`

## Requirements
- R1: After reset, all mode outputs and command outputs are 0, `burst_len` equals DEF_BURST (4), `addr_limit` equals DEF_LIMIT and `refr_period` equals DEF_REFR.
- R2: `bus_ardy` is always 1. A read sampled at a clock edge produces `bus_drdy` high for exactly the following cycle, with `bus_rdata` valid in that cycle. `bus_drdy` is 0 in every other cycle.
- R3: The control word (offset 0x00) is write-only and reads as 0. Any offset not listed in R9, R11 or R12 also reads as 0, including 0x1C and 0x40 and above.
- R4: Writes take effect only in the bytes whose `bus_be` bit is set, separately for each register. A control write with `bus_be[0]`=0 changes no mode and issues no command.
- R5: Control bit 2 (run) produces one cycle of `cmd_run` after a write that sets it while its last written value was 0. Writing 1 again produces no pulse.
- R6: Control bit 0 (tester reset) produces one cycle of `cmd_tester_rst` on the same rising-edge rule, and this command clears the sticky ECC flag.
- R7: Control bit 1 (controller reset), on a 0-to-1 write, drives `ctrl_rst_req` high for exactly RST_HOLD cycles (default 2) starting the cycle after the write.
- R8: Control bits 3 (manual access), 4 (random addressing), 5 (single outstanding read) and 6 (auto precharge) appear on `mode_manual`, `mode_rand_addr`, `mode_single_rd` and `mode_auto_pre` from the cycle after the write and hold until the next control write.
- R9: Status at offset 0x04 reads bit0 `test_done`, bit1 `test_pass`, bit2 sticky ECC, bit3 `cal_ok`, bit4 `cal_fail`, bit5 `mem_ready`, and 0 in the upper bits. All bits except bit2 show the inputs at the read edge.
- R10: An `ecc_irq` high at any edge sets the ECC flag. The flag stays set until a tester reset command, and an interrupt wins over a clear in the same cycle.
- R11: Offset 0x14 is writable, reads back, and drives `refr_period`. Offset 0x18 reads the constant DEF_REFR. `refr_period` changes only on writes to 0x14.
- R12: Offset 0x08 reads the `err_count` input. Offset 0x0C holds a BURST_W-bit burst length and offset 0x10 a LIMIT_W-bit address limit. Both are writable, and the upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_ardy | output | 1 | Address ready, always 1 |
| bus_rdata | output | 32 | Read data |
| bus_drdy | output | 1 | Read data valid pulse |
| test_done | input | 1 | Sequencer finished |
| test_pass | input | 1 | Sequencer result |
| err_count | input | 32 | Sequencer error count |
| ecc_irq | input | 1 | Controller ECC interrupt |
| cal_ok | input | 1 | Calibration succeeded |
| cal_fail | input | 1 | Calibration failed |
| mem_ready | input | 1 | Controller ready |
| cmd_tester_rst | output | 1 | Tester reset pulse |
| cmd_run | output | 1 | Run pulse |
| ctrl_rst_req | output | 1 | Stretched controller reset request |
| mode_manual | output | 1 | Manual access path select |
| mode_rand_addr | output | 1 | Random addressing |
| mode_single_rd | output | 1 | One outstanding read |
| mode_auto_pre | output | 1 | Auto precharge |
| burst_len | output | BURST_W | Burst length |
| addr_limit | output | LIMIT_W | Tested address limit |
| refr_period | output | REFR_W | Refresh period |

## Verification
The assertions check on every cycle the rules that depend only on local timing. These are: the read handshake follows the read strobe one cycle later, a command pulse lasts one cycle and has a matching write behind it, the controller reset request never lasts a single cycle, the ECC flag latches and holds, and the refresh period stays stable without a write to its offset. Other behaviour needs the bench's scenarios to show it. This covers the decoded read values at each offset, byte-lane merging against a reference model, the exact hold length of the reset request, the absence of a pulse when a command bit is written 1 twice, and the clearing of the ECC flag by a tester reset.

// File: rtl/memtest_csr_pkg.sv
package memtest_csr_pkg;
  localparam int CSR_DW = 32;
  localparam int CSR_BEW = CSR_DW / 8;

  // Register byte offsets
  localparam int OFF_CTL    = 'h00;
  localparam int OFF_STAT   = 'h04;
  localparam int OFF_ERRS   = 'h08;
  localparam int OFF_BURST  = 'h0C;
  localparam int OFF_LIMIT  = 'h10;
  localparam int OFF_REFR   = 'h14;
  localparam int OFF_REFDEF = 'h18;

  // Control word bit positions
  localparam int CB_TRST   = 0;
  localparam int CB_CRST   = 1;
  localparam int CB_RUN    = 2;
  localparam int CB_MODE0  = 3;
  localparam int N_CMD     = 3;
  localparam int N_MODE    = 4;

  // Status word bit positions
  localparam int SB_DONE  = 0;
  localparam int SB_PASS  = 1;
  localparam int SB_ECC   = 2;
  localparam int SB_CALOK = 3;
  localparam int SB_CALNG = 4;
  localparam int SB_READY = 5;
endpackage

// File: rtl/memtest_csr_cmd.sv
module memtest_csr_cmd
  import memtest_csr_pkg::*;
#(
  parameter int RST_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_ctl,
  input  logic [N_CMD-1:0] cmd_in,
  output logic             tst_rst_p,
  output logic             run_p,
  output logic             crst_req
);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(RST_HOLD);

  logic [N_CMD-1:0] prev_q, prev_d, rise;
  logic             tst_q, tst_d, run_q, run_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;

  // Edge detection per command bit
  for (genvar i = 0; i < N_CMD; i++) begin : g_edge
    assign rise[i]   = we_ctl && cmd_in[i] && !prev_q[i];
    assign prev_d[i] = we_ctl ? cmd_in[i] : prev_q[i];
  end

  always_comb begin
    tst_d = rise[CB_TRST];
    run_d = rise[CB_RUN];
    if (rise[CB_CRST])
      cnt_d = HOLD_LOAD;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      tst_q  <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      tst_q  <= tst_d;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
    end
  end

  assign tst_rst_p = tst_q;
  assign run_p     = run_q;
  assign crst_req  = (cnt_q != '0);

  // R5: pulses last one cycle and come from a write that set the bit
  assert_run_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_p |=> !run_p);
  assert_run_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_p |-> $past(we_ctl && cmd_in[CB_RUN]));
  // R6: tester reset pulse is a single cycle
  assert_trst_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tst_rst_p |=> !tst_rst_p);
  // R7: controller reset request never shorter than two cycles
  assert_crst_min_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crst_req) |=> crst_req);
endmodule

// File: rtl/memtest_csr_status.sv
module memtest_csr_status
  import memtest_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_done,
  input  logic              test_pass,
  input  logic              ecc_irq,
  input  logic              cal_ok,
  input  logic              cal_fail,
  input  logic              mem_ready,
  input  logic              ecc_clr,
  output logic [CSR_DW-1:0] status
);
  logic ecc_q, ecc_d;

  // Set wins over clear
  always_comb begin
    if (ecc_irq)
      ecc_d = 1'b1;
    else if (ecc_clr)
      ecc_d = 1'b0;
    else
      ecc_d = ecc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecc_q <= 1'b0;
    else        ecc_q <= ecc_d;
  end

  always_comb begin
    status            = '0;
    status[SB_DONE]   = test_done;
    status[SB_PASS]   = test_pass;
    status[SB_ECC]    = ecc_q;
    status[SB_CALOK]  = cal_ok;
    status[SB_CALNG]  = cal_fail;
    status[SB_READY]  = mem_ready;
  end

  // R10: interrupt latches, flag holds without a clear
  assert_ecc_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_irq |=> status[SB_ECC]);
  assert_ecc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[SB_ECC] && !ecc_clr) |=> status[SB_ECC]);
endmodule

// File: rtl/memtest_csr_regs.sv
module memtest_csr_regs
  import memtest_csr_pkg::*;
#(
  parameter int          BURST_W   = 7,
  parameter int          DEF_BURST = 4,
  parameter int          LIMIT_W   = 26,
  parameter int unsigned DEF_LIMIT = 32'h03FF_FF80,
  parameter int          REFR_W    = 32,
  parameter int unsigned DEF_REFR  = 32'h0000_0600
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CSR_DW-1:0]  wdata,
  input  logic [CSR_BEW-1:0] be,
  input  logic               we_ctl,
  input  logic               we_burst,
  input  logic               we_limit,
  input  logic               we_refr,
  output logic [N_MODE-1:0]  mode,
  output logic [BURST_W-1:0] burst,
  output logic [LIMIT_W-1:0] limit,
  output logic [REFR_W-1:0]  refr
);
  logic [N_MODE-1:0]  mode_q, mode_d;
  logic [BURST_W-1:0] burst_q, burst_d;
  logic [LIMIT_W-1:0] limit_q, limit_d;
  logic [REFR_W-1:0]  refr_q, refr_d;

  // Byte-lane merge, bit by bit so any width works
  always_comb begin
    mode_d  = mode_q;
    burst_d = burst_q;
    limit_d = limit_q;
    refr_d  = refr_q;
    if (we_ctl)
      mode_d = wdata[CB_MODE0 +: N_MODE];
    if (we_burst)
      for (int b = 0; b < BURST_W; b++)
        if (be[b/8]) burst_d[b] = wdata[b];
    if (we_limit)
      for (int b = 0; b < LIMIT_W; b++)
        if (be[b/8]) limit_d[b] = wdata[b];
    if (we_refr)
      for (int b = 0; b < REFR_W; b++)
        if (be[b/8]) refr_d[b] = wdata[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      burst_q <= BURST_W'(DEF_BURST);
      limit_q <= LIMIT_W'(DEF_LIMIT);
      refr_q  <= REFR_W'(DEF_REFR);
    end else begin
      mode_q  <= mode_d;
      burst_q <= burst_d;
      limit_q <= limit_d;
      refr_q  <= refr_d;
    end
  end

  assign mode  = mode_q;
  assign burst = burst_q;
  assign limit = limit_q;
  assign refr  = refr_q;

  // R11: refresh period moves only on its own write
  assert_refr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we_refr |=> $stable(refr));
  // R8: modes hold between control writes
  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ctl |=> $stable(mode));
endmodule

// File: rtl/memtest_csr.sv
module memtest_csr
  import memtest_csr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          BURST_W   = 7,
  parameter int          DEF_BURST = 4,
  parameter int          LIMIT_W   = 26,
  parameter int unsigned DEF_LIMIT = 32'h03FF_FF80,
  parameter int          REFR_W    = 32,
  parameter int unsigned DEF_REFR  = 32'h0000_0600,
  parameter int          RST_HOLD  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic               bus_ardy,
  output logic [31:0]        bus_rdata,
  output logic               bus_drdy,
  input  logic               test_done,
  input  logic               test_pass,
  input  logic [31:0]        err_count,
  input  logic               ecc_irq,
  input  logic               cal_ok,
  input  logic               cal_fail,
  input  logic               mem_ready,
  output logic               cmd_tester_rst,
  output logic               cmd_run,
  output logic               ctrl_rst_req,
  output logic               mode_manual,
  output logic               mode_rand_addr,
  output logic               mode_single_rd,
  output logic               mode_auto_pre,
  output logic [BURST_W-1:0] burst_len,
  output logic [LIMIT_W-1:0] addr_limit,
  output logic [REFR_W-1:0]  refr_period
);
  localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFF_CTL);
  localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_ERRS   = ADDR_W'(OFF_ERRS);
  localparam logic [ADDR_W-1:0] A_BURST  = ADDR_W'(OFF_BURST);
  localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(OFF_LIMIT);
  localparam logic [ADDR_W-1:0] A_REFR   = ADDR_W'(OFF_REFR);
  localparam logic [ADDR_W-1:0] A_REFDEF = ADDR_W'(OFF_REFDEF);

  logic we_ctl, we_burst, we_limit, we_refr;
  logic [N_MODE-1:0] mode;
  logic [CSR_DW-1:0] status;
  logic [CSR_DW-1:0] rd_mux;
  logic [CSR_DW-1:0] rdata_q, rdata_d;
  logic              drdy_q, drdy_d;
  logic              tst_p;

  // Write decode; control word lives in byte lane 0
  always_comb begin
    we_ctl   = bus_wr && (bus_addr == A_CTL) && bus_be[0];
    we_burst = bus_wr && (bus_addr == A_BURST);
    we_limit = bus_wr && (bus_addr == A_LIMIT);
    we_refr  = bus_wr && (bus_addr == A_REFR);
  end

  memtest_csr_cmd #(.RST_HOLD(RST_HOLD)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_ctl    (we_ctl),
    .cmd_in    (bus_wdata[N_CMD-1:0]),
    .tst_rst_p (tst_p),
    .run_p     (cmd_run),
    .crst_req  (ctrl_rst_req)
  );

  memtest_csr_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_done (test_done),
    .test_pass (test_pass),
    .ecc_irq   (ecc_irq),
    .cal_ok    (cal_ok),
    .cal_fail  (cal_fail),
    .mem_ready (mem_ready),
    .ecc_clr   (tst_p),
    .status    (status)
  );

  memtest_csr_regs #(
    .BURST_W  (BURST_W),  .DEF_BURST (DEF_BURST),
    .LIMIT_W  (LIMIT_W),  .DEF_LIMIT (DEF_LIMIT),
    .REFR_W   (REFR_W),   .DEF_REFR  (DEF_REFR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdata    (bus_wdata),
    .be       (bus_be),
    .we_ctl   (we_ctl),
    .we_burst (we_burst),
    .we_limit (we_limit),
    .we_refr  (we_refr),
    .mode     (mode),
    .burst    (burst_len),
    .limit    (addr_limit),
    .refr     (refr_period)
  );

  assign cmd_tester_rst = tst_p;
  assign mode_manual    = mode[0];
  assign mode_rand_addr = mode[1];
  assign mode_single_rd = mode[2];
  assign mode_auto_pre  = mode[3];

  // Read mux; control word and unmapped offsets read zero
  always_comb begin
    case (bus_addr)
      A_STAT:   rd_mux = status;
      A_ERRS:   rd_mux = err_count;
      A_BURST:  rd_mux = CSR_DW'(burst_len);
      A_LIMIT:  rd_mux = CSR_DW'(addr_limit);
      A_REFR:   rd_mux = CSR_DW'(refr_period);
      A_REFDEF: rd_mux = CSR_DW'(REFR_W'(DEF_REFR));
      default:  rd_mux = '0;
    endcase
  end

  always_comb begin
    drdy_d  = bus_rd;
    rdata_d = bus_rd ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drdy_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      drdy_q  <= drdy_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_ardy  = 1'b1;
  assign bus_drdy  = drdy_q;
  assign bus_rdata = rdata_q;

  // R2: data-ready follows a read by exactly one cycle
  assert_drdy_after_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_drdy);
  assert_drdy_only_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_drdy);
  // R4: control write without lane 0 leaves modes alone
  assert_ctl_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_be[0] && (bus_addr == A_CTL)) |=> $stable(mode) && !cmd_run);
  // R7: a lone request cycle never appears
  assert_crst_no_glitch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rst_req) |-> $past(ctrl_rst_req, 2));
endmodule

// File: tb/memtest_csr_bench.sv
`timescale 1ns/1ps
module memtest_csr_bench;
  localparam int unsigned DEF_LIMIT = 32'h03FF_FF80;
  localparam int unsigned DEF_REFR  = 32'h0000_0600;
  localparam logic [31:0] BMASK = 32'h7F;
  localparam logic [31:0] LMASK = 32'h03FF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ardy, bus_drdy;
  logic [31:0] bus_rdata;
  logic test_done = 0, test_pass = 0, ecc_irq = 0, cal_ok = 0, cal_fail = 0, mem_ready = 0;
  logic [31:0] err_count = '0;
  logic cmd_tester_rst, cmd_run, ctrl_rst_req;
  logic mode_manual, mode_rand_addr, mode_single_rd, mode_auto_pre;
  logic [6:0] burst_len;
  logic [25:0] addr_limit;
  logic [31:0] refr_period;

  int checks = 0, fails = 0;
  logic [31:0] m_burst, m_limit, m_refr;
  logic [3:0]  m_mode;
  logic        m_ecc;

  always #2.5 clk = ~clk;

  memtest_csr u_memtest_csr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ardy(bus_ardy), .bus_rdata(bus_rdata),
    .bus_drdy(bus_drdy), .test_done(test_done), .test_pass(test_pass), .err_count(err_count),
    .ecc_irq(ecc_irq), .cal_ok(cal_ok), .cal_fail(cal_fail), .mem_ready(mem_ready),
    .cmd_tester_rst(cmd_tester_rst), .cmd_run(cmd_run), .ctrl_rst_req(ctrl_rst_req),
    .mode_manual(mode_manual), .mode_rand_addr(mode_rand_addr), .mode_single_rd(mode_single_rd),
    .mode_auto_pre(mode_auto_pre), .burst_len(burst_len), .addr_limit(addr_limit),
    .refr_period(refr_period)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = n[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_status();
    return {26'd0, mem_ready, cal_fail, cal_ok, m_ecc, test_pass, test_done};
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h04: return exp_status();
      8'h08: return err_count;
      8'h0C: return m_burst;
      8'h10: return m_limit;
      8'h14: return m_refr;
      8'h18: return DEF_REFR;
      default: return 32'h0;
    endcase
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input string req);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check(bus_drdy === 1'b1, "R2", {31'd0, bus_drdy}, 32'd1);
    d = bus_rdata;
    @(negedge clk);
    check(bus_drdy === 1'b0, "R2", {31'd0, bus_drdy}, 32'd0);
  endtask

  task automatic rd_cmp(input logic [7:0] a, input string req);
    logic [31:0] d;
    rd(a, d, req);
    check(d === exp_read(a), req, d, exp_read(a));
  endtask

  task automatic chk_modes(input string req);
    logic [3:0] act = {mode_auto_pre, mode_single_rd, mode_rand_addr, mode_manual};
    check(act === m_mode, req, {28'd0, act}, {28'd0, m_mode});
  endtask

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd20240);
    m_burst = 4; m_limit = DEF_LIMIT; m_refr = DEF_REFR; m_mode = 0; m_ecc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state, R2 ardy
    chk_modes("R1");
    check({cmd_run, cmd_tester_rst, ctrl_rst_req} === 3'b000, "R1", {29'd0, cmd_run, cmd_tester_rst, ctrl_rst_req}, 0);
    check(burst_len === 7'd4, "R1", {25'd0, burst_len}, 4);
    check(addr_limit === DEF_LIMIT[25:0], "R1", {6'd0, addr_limit}, DEF_LIMIT);
    check(refr_period === DEF_REFR, "R1", refr_period, DEF_REFR);
    check(bus_ardy === 1'b1 && bus_drdy === 1'b0, "R2", {30'd0, bus_ardy, bus_drdy}, 32'd2);
    rd_cmp(8'h0C, "R12"); rd_cmp(8'h10, "R12"); rd_cmp(8'h14, "R11"); rd_cmp(8'h18, "R11");

    // R3 control and unmapped read zero
    wr(8'h00, 32'h0000_0078, 4'hF); m_mode = 4'hF;
    chk_modes("R8");
    rd_cmp(8'h00, "R3"); rd_cmp(8'h1C, "R3"); rd_cmp(8'h40, "R3"); rd_cmp(8'h7C, "R3");

    // R9 status layout, R12 error count
    {test_done, test_pass, cal_ok, cal_fail, mem_ready} = 5'b10101;
    err_count = 32'hDEAD_0007;
    rd_cmp(8'h04, "R9"); rd_cmp(8'h08, "R12");
    {test_done, test_pass, cal_ok, cal_fail, mem_ready} = 5'b01010;
    rd_cmp(8'h04, "R9");

    // R5 run pulse on rising edge only
    wr(8'h00, 32'h0, 4'h1); m_mode = 0;
    wr(8'h00, 32'h4, 4'h1);
    check(cmd_run === 1'b1, "R5", {31'd0, cmd_run}, 1);
    @(negedge clk);
    check(cmd_run === 1'b0, "R5", {31'd0, cmd_run}, 0);
    wr(8'h00, 32'h4, 4'h1);
    check(cmd_run === 1'b0, "R5", {31'd0, cmd_run}, 0);
    // R4 no lane 0: no command, no mode change
    wr(8'h00, 32'h0, 4'h1);
    wr(8'h00, 32'h0000_007C, 4'hE);
    check(cmd_run === 1'b0, "R4", {31'd0, cmd_run}, 0);
    chk_modes("R4");

    // R7 controller reset request width
    wr(8'h00, 32'h2, 4'h1);
    check(ctrl_rst_req === 1'b1, "R7", {31'd0, ctrl_rst_req}, 1);
    @(negedge clk);
    check(ctrl_rst_req === 1'b1, "R7", {31'd0, ctrl_rst_req}, 1);
    @(negedge clk);
    check(ctrl_rst_req === 1'b0, "R7", {31'd0, ctrl_rst_req}, 0);
    wr(8'h00, 32'h0, 4'h1);

    // R10 sticky ECC, R6 clear by tester reset
    ecc_irq = 1; @(negedge clk); ecc_irq = 0; m_ecc = 1;
    @(negedge clk);
    rd_cmp(8'h04, "R10");
    rd_cmp(8'h04, "R10");
    wr(8'h00, 32'h1, 4'h1);
    check(cmd_tester_rst === 1'b1, "R6", {31'd0, cmd_tester_rst}, 1);
    @(negedge clk);
    check(cmd_tester_rst === 1'b0, "R6", {31'd0, cmd_tester_rst}, 0);
    wr(8'h00, 32'h0, 4'h1); m_ecc = 0;
    rd_cmp(8'h04, "R6");

    // R11 refresh register with partial lanes
    wr(8'h14, 32'hA5A5_1234, 4'h3); m_refr = merge(m_refr, 32'hA5A5_1234, 4'h3);
    check(refr_period === m_refr, "R11", refr_period, m_refr);
    rd_cmp(8'h14, "R11"); rd_cmp(8'h18, "R11");

    // Constrained random register traffic, R4 R8 R11 R12
    for (int it = 0; it < 300; it++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [3:0]  be;
      int sel = $urandom_range(0, 4);
      d = $urandom; be = 4'($urandom);
      case (sel)
        0: begin a = 8'h00; d[2:0] = 3'b000; if (be[0]) m_mode = d[6:3]; end
        1: begin a = 8'h0C; m_burst = merge(m_burst, d, be) & BMASK; end
        2: begin a = 8'h10; m_limit = merge(m_limit, d, be) & LMASK; end
        3: begin a = 8'h14; m_refr = merge(m_refr, d, be); end
        default: begin a = 8'h08; err_count = $urandom; end
      endcase
      wr(a, d, be);
      chk_modes("R8");
      check(refr_period === m_refr, "R11", refr_period, m_refr);
      rd_cmp(a == 8'h00 ? 8'h0C : a, (sel == 3) ? "R11" : "R12");
    end
    check({25'd0, burst_len} === m_burst, "R12", {25'd0, burst_len}, m_burst);
    check({6'd0, addr_limit} === m_limit, "R4", {6'd0, addr_limit}, m_limit);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule